// File: doc/BRIEF.md
# SPI Chip-Select Sequencer

This block owns the chip-select wires of an SPI host. It drives a configurable number of select lines (up to 32). Each line has its own idle level. A chosen line is driven to the opposite of its idle level while a device is addressed. Four 8-bit delays govern the timing, each counted in serial-clock periods that a divider marks with a one-cycle tick:

- lead: select asserted to first clock;
- trail: last clock to select release;
- quiet: minimum time a select stays released;
- gap: pause between frames while the select is kept low.

The shift engine asks for a frame with a request level. It may start shifting only when the sequencer returns a one-cycle grant, and it reports the end of the frame with a done pulse. Three select policies exist:

- **per-frame** (code 0): the line is asserted around every frame.
- **keep** (code 2): the line stays asserted from the first frame until the policy or the chosen index changes.
- **none** (code 3): frames are granted but no line is ever driven active.

Code 1 behaves as per-frame. Software finds out how many lines exist by writing all ones to the idle-level register and reading it back, because only implemented bits hold a value.

Top module: `cs_sequencer`

## Requirements
- R1: While reset is held and after it is released, every select line sits at its idle level, the idle readback is all ones over the implemented lines (0xF for four lines), and no grant is given.
- R2: A write with select code 0 loads idle levels from write-data bits [NUM_CS-1:0]. The readback shows them one cycle later, and the higher bits read 0. While no frame is active, each line equals its idle bit.
- R3: While asserted, only the chosen line is driven to the inverse of its idle bit, and all other lines keep their idle bits. An index of NUM_CS or above drives no line active, although the frame is still granted.
- R4: Write code 1 places the lead delay in bits [7:0]. With the tick high every cycle, the grant appears lead+1 cycles after the line asserts. With slower ticks, exactly lead ticks must pass before the grant.
- R5: Write code 1 places the trail delay in bits [23:16]. In per-frame policy, with the tick always high, the line releases trail+2 cycles after the cycle in which done is presented.
- R6: Write code 2 places the quiet time in bits [7:0]. With a request pending and the tick always high, a released line re-asserts quiet+2 cycles after release.
- R7: Write code 2 places the gap in bits [23:16]. In keep policy the line stays asserted between frames and while idle. With a request pending, the next grant comes gap+3 cycles after done is presented.
- R8: In keep policy, changing the index or leaving the policy while the line is held releases the line trail+2 cycles later. A new line then asserts only after the quiet time.
- R9: In none policy no line ever asserts. A request in the idle state is granted one cycle after it is presented. A following request is granted gap+3 cycles after done.
- R10: After reset the delays are lead 1, trail 1, quiet 1 and gap 0.
- R11: Every grant lasts exactly one cycle, and only one grant is issued per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | Write target: 0 idle levels, 1 lead/trail, 2 quiet/gap |
| cfg_wr_data | input | 32 | Write data |
| cfg_sel_idx | input | 5 | Index of the line to address |
| cfg_mode | input | 2 | Select policy: 0 per-frame, 2 keep, 3 none |
| sck_tick | input | 1 | One pulse per serial-clock period, timebase of the delays |
| frame_req | input | 1 | Shift engine wants to start a frame |
| frame_done | input | 1 | Shift engine finished its frame (one-cycle pulse) |
| frame_go | output | 1 | One-cycle grant: the engine may start shifting |
| idle_rd | output | 32 | Idle-level readback, unimplemented bits zero |
| cs_lines | output | NUM_CS | Select line levels |

## Verification
The first checks run with the tick held high, so every delay becomes a whole number of clock cycles. The bench timestamps each event at the falling edge on which it is seen and compares the differences:

- grant after assertion: lead+1 cycles;
- release after done: trail+2 cycles;
- re-assertion after release: quiet+2 cycles;
- keep-mode grant after done: gap+3 cycles;
- none-mode grant after request: 1 cycle;
- configuration readback: the cycle after the write.

These counts follow from one register stage on the request or done path, the loaded counter, and the registered grant. With a four-cycle tick the lead check instead accepts the window [4·lead−2, 4·lead+1], because the phase of the tick against the request is not fixed. Waits on lines or grants stop after a bounded count, so a missing event is reported rather than hanging the run.

// File: rtl/cs_seq_pkg.sv
// Package: shared types and constants for the chip-select sequencer.
// Assumes at most 32 select lines and 8-bit delay fields.
package cs_seq_pkg;
    localparam int MAX_LINES = 32;
    localparam int SEL_W     = $clog2(MAX_LINES);
    localparam int DLY_W     = 8;

    // select policies; codes are fixed by software
    typedef enum logic [1:0] {
        CSM_AUTO = 2'd0,
        CSM_RSVD = 2'd1,
        CSM_HOLD = 2'd2,
        CSM_OFF  = 2'd3
    } csmode_e;

    // write targets of the configuration port
    localparam logic [1:0] WSEL_IDLE = 2'd0;
    localparam logic [1:0] WSEL_DLYA = 2'd1;
    localparam logic [1:0] WSEL_DLYB = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_XFER, ST_TAIL, ST_GAP, ST_INACT, ST_HELD
    } seq_state_e;

    typedef struct packed {
        logic [DLY_W-1:0] lead;   // select to first clock
        logic [DLY_W-1:0] trail;  // last clock to release
        logic [DLY_W-1:0] quiet;  // minimum released time
        logic [DLY_W-1:0] gap;    // pause between held frames
    } dly_set_t;
endpackage

// File: rtl/cs_cfg_regs.sv
// cs_cfg_regs: holds idle levels and the four delays.
// Only NUM_LINES idle bits exist, so unimplemented bits cannot be written.
// Assumes a single write strobe with a 2-bit target code.
module cs_cfg_regs
    import cs_seq_pkg::*;
#(
    parameter int NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [31:0]          wr_data,
    output logic [NUM_LINES-1:0] idle_lvl,
    output dly_set_t             dly
);
    // idle levels: all lines idle high after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_lvl <= '1;
        end else if (wr_en && wr_sel == WSEL_IDLE) begin
            idle_lvl <= wr_data[NUM_LINES-1:0];
        end
    end

    // delay fields: fixed reset values, two words of two fields each
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly.lead  <= DLY_W'(1);
            dly.trail <= DLY_W'(1);
            dly.quiet <= DLY_W'(1);
            dly.gap   <= '0;
        end else if (wr_en && wr_sel == WSEL_DLYA) begin
            dly.lead  <= wr_data[7:0];
            dly.trail <= wr_data[23:16];
        end else if (wr_en && wr_sel == WSEL_DLYB) begin
            dly.quiet <= wr_data[7:0];
            dly.gap   <= wr_data[23:16];
        end
    end

    // R2: an idle write shows up on the next cycle
    p_idle_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == WSEL_IDLE) |=> (idle_lvl == $past(wr_data[NUM_LINES-1:0])));
endmodule

// File: rtl/cs_delay_timer.sv
// cs_delay_timer: loadable down-counter advanced by the serial-clock tick.
// Reports expiry when the count reaches zero; a load of 0 expires at once.
module cs_delay_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expired
);
    logic [W-1:0] cnt;

    // count down one per tick until zero
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (load)            cnt <= load_val;
        else if (tick && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R5: once expired the counter stays at zero until reloaded
    p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);
endmodule

// File: rtl/cs_seq_fsm.sv
// cs_seq_fsm: sequences select assertion, grants and the four delays.
// Latches index and policy when a frame starts from idle.
// Assumes frame_done only arrives after a grant.
module cs_seq_fsm
    import cs_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [SEL_W-1:0] idx_i,
    input  dly_set_t         dly,
    input  logic             frame_req,
    input  logic             frame_done,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [DLY_W-1:0] tmr_val,
    output logic             frame_go,
    output logic             cs_on,
    output logic [SEL_W-1:0] sel_idx
);
    seq_state_e       state, state_n;
    csmode_e          cur_mode, mode_n;
    logic [SEL_W-1:0] idx_n;
    logic             go_n;

    // next-state, timer load and grant decision
    always_comb begin
        state_n  = state;
        mode_n   = cur_mode;
        idx_n    = sel_idx;
        go_n     = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: if (frame_req) begin
                mode_n = csmode_e'(mode_i);
                idx_n  = idx_i;
                if (csmode_e'(mode_i) == CSM_OFF) begin
                    state_n = ST_XFER;
                    go_n    = 1'b1;
                end else begin
                    state_n  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = dly.lead;
                end
            end
            ST_SETUP: if (tmr_expired) begin
                state_n = ST_XFER;
                go_n    = 1'b1;
            end
            ST_XFER: if (frame_done) begin
                tmr_load = 1'b1;
                if (cur_mode == CSM_OFF || cur_mode == CSM_HOLD) begin
                    state_n = ST_GAP;
                    tmr_val = dly.gap;
                end else begin
                    state_n = ST_TAIL;
                    tmr_val = dly.trail;
                end
            end
            ST_TAIL: if (tmr_expired) begin
                state_n  = ST_INACT;
                tmr_load = 1'b1;
                tmr_val  = dly.quiet;
            end
            ST_INACT: if (tmr_expired) state_n = ST_IDLE;
            ST_GAP: if (tmr_expired) begin
                state_n = (cur_mode == CSM_HOLD) ? ST_HELD : ST_IDLE;
            end
            ST_HELD: begin
                if (csmode_e'(mode_i) != CSM_HOLD || idx_i != sel_idx) begin
                    state_n  = ST_TAIL;
                    tmr_load = 1'b1;
                    tmr_val  = dly.trail;
                end else if (frame_req) begin
                    state_n = ST_XFER;
                    go_n    = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state, latched frame settings and registered grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_mode <= CSM_AUTO;
            sel_idx  <= '0;
            frame_go <= 1'b0;
        end else begin
            state    <= state_n;
            cur_mode <= mode_n;
            sel_idx  <= idx_n;
            frame_go <= go_n;
        end
    end

    // select is driven in setup, tail and held, and in transfer or gap unless policy is none
    always_comb begin
        cs_on = (state == ST_SETUP) || (state == ST_TAIL) || (state == ST_HELD) ||
                (((state == ST_XFER) || (state == ST_GAP)) && cur_mode != CSM_OFF);
    end

    // R11: a grant lasts a single cycle
    p_grant_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_go |=> !frame_go);
    // R4: a grant under an asserting policy finds the select already active
    p_grant_after_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_go && cur_mode != CSM_OFF) |-> cs_on);
    // R5: the select is only ever released out of the trail delay
    p_release_via_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_on) |-> ($past(state) == ST_TAIL));
    // R9: policy none never drives the select
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == CSM_OFF && state != ST_IDLE) |-> !cs_on);
endmodule

// File: rtl/cs_line_drive.sv
// cs_line_drive: maps the active flag and index to per-line levels.
// A line at its idle level is inactive; the active line is the inverse.
module cs_line_drive
    import cs_seq_pkg::*;
#(
    parameter int NUM_LINES = 4
) (
    input  logic [NUM_LINES-1:0] idle_lvl,
    input  logic                 cs_on,
    input  logic [SEL_W-1:0]     sel_idx,
    output logic [NUM_LINES-1:0] lines
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        // invert only the chosen line while active
        assign lines[i] = (cs_on && sel_idx == SEL_W'(i)) ? ~idle_lvl[i] : idle_lvl[i];
    end
endmodule

// File: rtl/cs_sequencer.sv
// cs_sequencer: top of the chip-select sequencer.
// Joins configuration, delay timer, sequencing FSM and line drivers.
// Assumes 1 <= NUM_CS <= 32 and a tick from the serial-clock divider.
module cs_sequencer
    import cs_seq_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_sel,
    input  logic [31:0]       cfg_wr_data,
    input  logic [SEL_W-1:0]  cfg_sel_idx,
    input  logic [1:0]        cfg_mode,
    input  logic              sck_tick,
    input  logic              frame_req,
    input  logic              frame_done,
    output logic              frame_go,
    output logic [31:0]       idle_rd,
    output logic [NUM_CS-1:0] cs_lines
);
    logic [NUM_CS-1:0] idle_lvl;
    dly_set_t          dly;
    logic              tmr_load, tmr_expired, cs_on;
    logic [DLY_W-1:0]  tmr_val;
    logic [SEL_W-1:0]  sel_idx;

    cs_cfg_regs #(.NUM_LINES(NUM_CS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
        .wr_data(cfg_wr_data), .idle_lvl(idle_lvl), .dly(dly)
    );

    cs_delay_timer #(.W(DLY_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .tick(sck_tick), .expired(tmr_expired)
    );

    cs_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_i(cfg_mode), .idx_i(cfg_sel_idx),
        .dly(dly), .frame_req(frame_req), .frame_done(frame_done),
        .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .frame_go(frame_go), .cs_on(cs_on), .sel_idx(sel_idx)
    );

    cs_line_drive #(.NUM_LINES(NUM_CS)) u_drv (
        .idle_lvl(idle_lvl), .cs_on(cs_on), .sel_idx(sel_idx), .lines(cs_lines)
    );

    // readback: implemented idle bits, zero above
    always_comb begin
        idle_rd = '0;
        idle_rd[NUM_CS-1:0] = idle_lvl;
    end

    // R3: at most one line differs from its idle level
    p_single_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_lines ^ idle_lvl));
endmodule

// File: tb/cs_sequencer_test.sv
`timescale 1ns/1ps
module cs_sequencer_test;
    localparam int N = 4;

    logic          clk = 0, rst_n = 0;
    logic          cfg_wr_en = 0;
    logic [1:0]    cfg_wr_sel = 0;
    logic [31:0]   cfg_wr_data = 0;
    logic [4:0]    cfg_sel_idx = 0;
    logic [1:0]    cfg_mode = 0;
    logic          sck_tick = 1;
    logic          frame_req = 0, frame_done = 0;
    logic          frame_go;
    logic [31:0]   idle_rd;
    logic [N-1:0]  cs_lines;

    int n_chk = 0, n_bad = 0, cyc = 0, tick_per = 1;
    logic [N-1:0] exp_idle = '1;

    cs_sequencer #(.NUM_CS(N)) uut (.*);

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // tick generator: every cycle or every tick_per cycles
    initial forever begin
        @(negedge clk);
        sck_tick = (tick_per <= 1) || (cyc % tick_per == 0);
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit line_act(input int k);
        return cs_lines[k] != exp_idle[k];
    endfunction

    task automatic wait_line(input int k, input bit act, output int t);
        int n = 0;
        do begin @(negedge clk); n++; end while (line_act(k) != act && n < 400);
        t = cyc;
        if (n >= 400) chk(0, "line wait timeout", k, act);
    endtask

    task automatic wait_go(output int t);
        int n = 0;
        do begin @(negedge clk); n++; end while (!frame_go && n < 400);
        t = cyc;
        if (n >= 400) chk(0, "grant wait timeout", 0, 1);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        cfg_wr_en = 1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    // engine side: confirm one-cycle grant, then present done one cycle
    task automatic finish_frame(output int t_d);
        @(negedge clk);
        chk(frame_go == 0, "R11 grant one cycle", frame_go, 0);
        @(negedge clk);
        frame_done = 1; t_d = cyc;
        @(negedge clk);
        frame_done = 0;
    endtask

    // two back-to-back per-frame cycles with delays c, s, q on line k
    task automatic run_auto(input int c, input int s, input int q, input int k,
                            input bit use_defaults);
        int t_on, t_go, t_d, t_off, t_on2;
        if (!use_defaults) begin
            wr(2'd1, (s << 16) | c);
            wr(2'd2, q);
        end
        cfg_mode = 2'd0; cfg_sel_idx = 5'(k); frame_req = 1;
        wait_line(k, 1, t_on);
        chk(cs_lines == (exp_idle ^ N'(1 << k)), "R3 active level", cs_lines, exp_idle ^ N'(1 << k));
        wait_go(t_go);
        chk(t_go - t_on == c + 1, "R4 lead to grant", t_go - t_on, c + 1);
        finish_frame(t_d);
        wait_line(k, 0, t_off);
        chk(t_off - t_d == s + 2, "R5 done to release", t_off - t_d, s + 2);
        wait_line(k, 1, t_on2);
        chk(t_on2 - t_off == q + 2, "R6 quiet time", t_on2 - t_off, q + 2);
        wait_go(t_go);
        frame_req = 0;
        finish_frame(t_d);
        wait_line(k, 0, t_off);
        repeat (q + 3) @(negedge clk);
        chk(cs_lines == exp_idle, "R2 idle levels after frame", cs_lines, exp_idle);
    endtask

    initial begin
        int t0, t1, t_d, t_x;
        repeat (3) @(negedge clk);
        // R1: state during and after reset
        chk(cs_lines == 4'hF, "R1 lines in reset", cs_lines, 4'hF);
        rst_n = 1;
        @(negedge clk);
        chk(cs_lines == 4'hF, "R1 lines idle", cs_lines, 4'hF);
        chk(idle_rd == 32'hF, "R1 idle readback", idle_rd, 32'hF);
        chk(frame_go == 0, "R1 no grant", frame_go, 0);

        // R10: reset delays lead 1, trail 1, quiet 1
        run_auto(1, 1, 1, 0, 1);

        // R2: only implemented bits hold a value
        wr(2'd0, 32'hFFFF_FFFF);
        chk(idle_rd == 32'hF, "R2 line count discovery", idle_rd, 32'hF);
        wr(2'd0, 32'hFFFF_FFF5); exp_idle = 4'h5;
        chk(idle_rd == 32'h5, "R2 readback", idle_rd, 32'h5);
        chk(cs_lines == 4'h5, "R2 idle drive", cs_lines, 4'h5);

        // R4 R5 R6 R3: sweep of delays, lines and idle patterns
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 4; s++)
                for (int q = 0; q < 4; q++) begin
                    exp_idle = N'(c * 4 + s + q);
                    wr(2'd0, 32'(exp_idle));
                    run_auto(c, s, q, (c + s + q) % N, 0);
                end

        // R3: index out of range drives nothing but still grants
        cfg_sel_idx = 5'd6; cfg_mode = 2'd0; frame_req = 1;
        wait_go(t0);
        chk(cs_lines == exp_idle, "R3 out-of-range index", cs_lines, exp_idle);
        frame_req = 0;
        finish_frame(t_d);
        repeat (12) @(negedge clk);

        // R7 R8: keep policy with gap sweep
        for (int g = 0; g < 4; g++) begin
            wr(2'd1, (2 << 16) | 1);
            wr(2'd2, (g << 16) | 1);
            cfg_mode = 2'd2; cfg_sel_idx = 5'd1; frame_req = 1;
            wait_line(1, 1, t0);
            wait_go(t1);
            chk(t1 - t0 == 2, "R4 lead in keep", t1 - t0, 2);
            finish_frame(t_d);
            wait_go(t1);
            chk(t1 - t_d == g + 3, "R7 gap to next grant", t1 - t_d, g + 3);
            chk(line_act(1), "R7 held between frames", line_act(1), 1);
            frame_req = 0;
            finish_frame(t_d);
            repeat (g + 4) @(negedge clk);
            chk(line_act(1), "R7 held while idle", line_act(1), 1);
            // index change releases after trail, new line after quiet
            cfg_sel_idx = 5'd2; frame_req = 1; t_x = cyc;
            wait_line(1, 0, t0);
            chk(t0 - t_x == 4, "R8 index change release", t0 - t_x, 4);
            wait_line(2, 1, t1);
            chk(t1 - t0 == 3, "R8 quiet before new line", t1 - t0, 3);
            wait_go(t1);
            frame_req = 0;
            finish_frame(t_d);
            repeat (g + 4) @(negedge clk);
            cfg_mode = 2'd0; t_x = cyc;
            wait_line(2, 0, t0);
            chk(t0 - t_x == 4, "R8 policy change release", t0 - t_x, 4);
            repeat (6) @(negedge clk);
        end

        // R9: policy none, gap sweep
        for (int g = 0; g < 4; g++) begin
            wr(2'd2, (g << 16) | 1);
            cfg_mode = 2'd3; cfg_sel_idx = 5'd3; frame_req = 1; t_x = cyc;
            wait_go(t1);
            chk(t1 - t_x == 1, "R9 immediate grant", t1 - t_x, 1);
            chk(cs_lines == exp_idle, "R9 no select", cs_lines, exp_idle);
            finish_frame(t_d);
            wait_go(t1);
            chk(t1 - t_d == g + 3, "R9 gap to next grant", t1 - t_d, g + 3);
            frame_req = 0;
            finish_frame(t_d);
            chk(cs_lines == exp_idle, "R9 no select after", cs_lines, exp_idle);
            repeat (g + 3) @(negedge clk);
        end

        // R4: lead counted in ticks of a slower serial clock
        tick_per = 4;
        for (int c = 1; c < 4; c++) begin
            wr(2'd1, (1 << 16) | c);
            cfg_mode = 2'd0; cfg_sel_idx = 5'd0; frame_req = 1;
            wait_line(0, 1, t0);
            wait_go(t1);
            chk((t1 - t0 >= 4 * c - 2) && (t1 - t0 <= 4 * c + 1), "R4 lead in ticks",
                t1 - t0, 4 * c);
            frame_req = 0;
            finish_frame(t_d);
            wait_line(0, 0, t0);
            repeat (16) @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule